// File: doc/BRIEF.md
# Compare-Match Watchdog Timer

This peripheral watches for a stalled processor, or serves as a plain periodic timer. Its count clock is an overflow pulse from a separate interval timer, which arrives on `tick_in` as a one-cycle pulse. A programmable divider passes every pulse, every 2nd, every 4th or every 8th pulse to an 8-bit up-counter. On a counted pulse where the counter equals the match value, the counter wraps to zero and a match event is raised. The time between two events is therefore the divided tick period times (match value + 1).

A mode bit decides what a match event does. In watchdog mode the event is a one-cycle reset request to the system reset logic. In timer mode the event sets an interrupt flag, and the flag holds until the interrupt is acknowledged. Software reaches the block through a byte-wide register bus with two addresses. Address 0 holds the mode register. Address 1 is shared: a write sets the match value and a read returns the live count. To keep a healthy system out of reset, software clears the counter through a self-clearing bit in the mode register.

Top module: `match_wdt`

## Requirements
- R1: After reset the mode register reads 0x00, the counter reads 0x00, and the match value is 0xFF. With no software setup beyond enabling, the first event comes on the 256th counted pulse.
- R2: Address 0 is the mode register. Bit 7 enables counting, bit 6 selects watchdog mode (1) or timer mode (0), bit 5 is the counter clear, and bits 1:0 are the divide select. Bits 4:2 always read 0.
- R3: While enabled, each counted pulse adds one to the counter. While the enable bit is 0 the counter holds its value, whatever `tick_in` does.
- R4: A divide select of 0, 1, 2 or 3 counts every 1st, 2nd, 4th or 8th tick. Any write to the mode register restarts the divider's internal count.
- R5: On a counted pulse where the counter equals the match value, the counter returns to 0 and a match event is raised. This gives match+1 counted pulses per event.
- R6: In timer mode, a match event sets `irq_o`, which stays high until `int_ack` is seen. An event in the same cycle as `int_ack` leaves the flag set.
- R7: In watchdog mode, a match event drives `rst_req_o` high for exactly one cycle and does not set `irq_o`.
- R8: Writing the mode register with bit 5 set clears the counter in that cycle. Bit 5 reads 1 for that one cycle and 0 afterwards. If the clear meets a match in the same cycle, the clear wins and no event is raised.
- R9: A write to address 1 changes only the match value. A read of address 1 returns the counter, never the match value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register address (0 mode, 1 match/count) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address |
| tick_in | input | 1 | One-cycle overflow pulse from the interval timer |
| int_ack | input | 1 | Interrupt acknowledge, clears the interrupt flag |
| irq_o | output | 1 | Pending match interrupt (timer mode) |
| rst_req_o | output | 1 | One-cycle reset request (watchdog mode) |

## Verification
The assertions place no timing limits on `tick_in`, `int_ack` or the write strobe; they may arrive in any cycle, even back to back. The divider bound assumes only one thing: the divide select changes through a mode-register write alone, since that write is what restarts the prescale count. The random stimulus therefore drives pulses, acknowledges and writes of every kind freely in any cycle. It keeps match values in the low 16 so that events, wraps and clear/match collisions happen often. Directed sequences cover the default 0xFF period, each mode and a divided rate.

// File: rtl/mwdt_pkg.sv
package mwdt_pkg;
    localparam int DATA_W  = 8;
    localparam int DIV_W   = 2;
    localparam int PRE_W   = (1 << DIV_W) - 1;
    localparam int ADDR_W  = 1;

    localparam logic [ADDR_W-1:0] ADDR_MODE = 1'b0;
    localparam logic [ADDR_W-1:0] ADDR_CNT  = 1'b1;

    localparam int EN_BIT  = 7;
    localparam int SEL_BIT = 6;
    localparam int CLR_BIT = 5;

    localparam logic [DATA_W-1:0] MATCH_RST = '1;

    typedef struct packed {
        logic             en;
        logic             sel;
        logic             clr;
        logic [DIV_W-1:0] div;
    } mode_t;
endpackage

// File: rtl/mwdt_prescale.sv
module mwdt_prescale
    import mwdt_pkg::*;
#(
    parameter int DW = DIV_W,
    parameter int PW = PRE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          en_i,
    input  logic [DW-1:0] div_i,
    input  logic          restart_i,
    output logic          step_o
);
    typedef struct packed {
        logic [PW-1:0] pre;
    } pre_t;

    pre_t          s_d, s_q;
    logic [PW-1:0] lim;
    logic          at_lim;

    always_comb begin
        for (int k = 0; k < PW; k++) begin
            lim[k] = (k < int'(div_i));
        end
        at_lim = (s_q.pre == lim);
        step_o = tick_i & en_i & at_lim;
        s_d    = s_q;
        if (restart_i) begin
            s_d.pre = '0;
        end else if (tick_i && en_i) begin
            s_d.pre = at_lim ? '0 : s_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R4: prescale count never passes the active limit
    assert_pre_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.pre <= lim);
endmodule

// File: rtl/mwdt_core.sv
module mwdt_core
    import mwdt_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_i,
    input  logic         clr_i,
    input  logic         sel_i,
    input  logic         ack_i,
    input  logic [W-1:0] match_i,
    output logic [W-1:0] cnt_o,
    output logic         irq_o,
    output logic         rreq_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         irq;
        logic         rreq;
    } core_t;

    core_t s_d, s_q;
    logic  at_match;
    logic  hit;

    always_comb begin
        at_match = (s_q.cnt == match_i);
        hit      = step_i & ~clr_i & at_match;
        s_d      = s_q;
        if (clr_i) begin
            s_d.cnt = '0;
        end else if (step_i) begin
            s_d.cnt = at_match ? '0 : s_q.cnt + 1'b1;
        end
        s_d.irq  = (hit & ~sel_i) | (s_q.irq & ~ack_i);
        s_d.rreq = hit & sel_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_o  = s_q.cnt;
    assign irq_o  = s_q.irq;
    assign rreq_o = s_q.rreq;

    // R3: no pulse and no clear means the count holds
    assert_cnt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !clr_i) |=> s_q.cnt == $past(s_q.cnt));
    // R5: a counted pulse at the match value wraps to zero
    assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !clr_i && s_q.cnt == match_i) |=> s_q.cnt == '0);
    // R6: a pending flag survives until acknowledged
    assert_irq_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.irq && !ack_i) |=> s_q.irq);
    // R7: reset request only in watchdog mode, never with a new interrupt
    assert_rreq_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.rreq |-> ($past(sel_i) && !$rose(s_q.irq)));
    // R8: a clear always wins over a coinciding match
    assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (s_q.cnt == '0 && !s_q.rreq));
endmodule

// File: rtl/match_wdt.sv
module match_wdt
    import mwdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick_in,
    input  logic              int_ack,
    output logic              irq_o,
    output logic              rst_req_o
);
    typedef struct packed {
        mode_t             mode;
        logic [DATA_W-1:0] match;
    } regs_t;

    regs_t             r_d, r_q;
    logic              wr_mode;
    logic              wr_match;
    logic              clr_w;
    logic              step_w;
    logic [DATA_W-1:0] cnt_w;
    logic              unused_wbits;

    assign unused_wbits = ^bus_wdata[CLR_BIT-1:DIV_W];

    always_comb begin
        wr_mode  = bus_we && (bus_addr == ADDR_MODE);
        wr_match = bus_we && (bus_addr == ADDR_CNT);
        clr_w    = wr_mode && bus_wdata[CLR_BIT];
        r_d      = r_q;
        r_d.mode.clr = clr_w;
        if (wr_mode) begin
            r_d.mode.en  = bus_wdata[EN_BIT];
            r_d.mode.sel = bus_wdata[SEL_BIT];
            r_d.mode.div = bus_wdata[DIV_W-1:0];
        end
        if (wr_match) begin
            r_d.match = bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.mode  <= '0;
            r_q.match <= MATCH_RST;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_CNT) begin
            bus_rdata = cnt_w;
        end else begin
            bus_rdata[EN_BIT]      = r_q.mode.en;
            bus_rdata[SEL_BIT]     = r_q.mode.sel;
            bus_rdata[CLR_BIT]     = r_q.mode.clr;
            bus_rdata[DIV_W-1:0]   = r_q.mode.div;
        end
    end

    mwdt_prescale #(.DW(DIV_W), .PW(PRE_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_in),
        .en_i     (r_q.mode.en),
        .div_i    (r_q.mode.div),
        .restart_i(wr_mode),
        .step_o   (step_w)
    );

    mwdt_core #(.W(DATA_W)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (step_w),
        .clr_i  (clr_w),
        .sel_i  (r_q.mode.sel),
        .ack_i  (int_ack),
        .match_i(r_q.match),
        .cnt_o  (cnt_w),
        .irq_o  (irq_o),
        .rreq_o (rst_req_o)
    );

    // R8: the clear bit is only ever seen right after a write that set it
    assert_clr_self_R8: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.mode.clr |-> $past(wr_mode && bus_wdata[CLR_BIT]));
    // R9: the match value moves only on a write to the shared address
    assert_match_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_match |=> r_q.match == $past(r_q.match));
endmodule

// File: tb/match_wdt_test.sv
`timescale 1ns/1ps
module match_wdt_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       tick_in = 1'b0;
    logic       int_ack = 1'b0;
    logic       irq_o;
    logic       rst_req_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // reference state
    logic       e_en, e_sel, e_clr;
    logic [1:0] e_div;
    logic [7:0] e_match, e_cnt;
    int         e_pre;
    logic       e_irq, e_rst;

    logic [7:0] got_rd;
    logic       got_irq, got_rst;

    always #2.5 clk = ~clk;

    match_wdt uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_in(tick_in),
        .int_ack(int_ack), .irq_o(irq_o), .rst_req_o(rst_req_o)
    );

    function automatic int div_lim(input logic [1:0] d);
        return (1 << d) - 1;
    endfunction

    function automatic logic [7:0] exp_rd(input logic a);
        if (a) return e_cnt;
        return {e_en, e_sel, e_clr, 3'b000, e_div};
    endfunction

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %02h expected %02h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic model_step(input logic we, input logic a, input logic [7:0] wd,
                              input logic tk, input logic ak);
        logic wrm, clr, stp, hit;
        wrm = we && !a;
        clr = wrm && wd[5];
        stp = tk && e_en && (e_pre == div_lim(e_div));
        hit = stp && !clr && (e_cnt == e_match);
        if (wrm) e_pre = 0;
        else if (tk && e_en) e_pre = (e_pre == div_lim(e_div)) ? 0 : e_pre + 1;
        if (clr) e_cnt = 8'h00;
        else if (stp) e_cnt = (e_cnt == e_match) ? 8'h00 : e_cnt + 8'h01;
        e_irq = (hit && !e_sel) || (e_irq && !ak);
        e_rst = hit && e_sel;
        e_clr = clr;
        if (wrm) begin
            e_en = wd[7]; e_sel = wd[6]; e_div = wd[1:0];
        end
        if (we && a) e_match = wd;
    endtask

    task automatic cyc(input logic we, input logic a, input logic [7:0] wd,
                       input logic tk, input logic ak);
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = wd; tick_in = tk; int_ack = ak;
        model_step(we, a, wd, tk, ak);
        @(posedge clk);
        #1;
        got_rd = bus_rdata; got_irq = irq_o; got_rst = rst_req_o;
        chk("R6 irq", {7'd0, got_irq}, {7'd0, e_irq});
        chk("R7 rst_req", {7'd0, got_rst}, {7'd0, e_rst});
        chk(a ? "R3 count read" : "R2 mode read", got_rd, exp_rd(a));
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: got hung expected finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        e_en = 0; e_sel = 0; e_clr = 0; e_div = 0; e_match = 8'hFF;
        e_cnt = 0; e_pre = 0; e_irq = 0; e_rst = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        cyc(0, 0, 8'h00, 0, 0); chk("R1 mode", got_rd, 8'h00);
        cyc(0, 1, 8'h00, 0, 0); chk("R1 count", got_rd, 8'h00);
        // R1 default match 0xFF: event on the 256th counted pulse
        cyc(1, 0, 8'h80, 0, 0);
        for (int i = 0; i < 255; i++) cyc(0, 1, 8'h00, 1, 0);
        chk("R1 count 255", got_rd, 8'hFF);
        chk("R1 no irq yet", {7'd0, got_irq}, 8'h00);
        cyc(0, 1, 8'h00, 1, 0);
        chk("R1 irq at 256", {7'd0, got_irq}, 8'h01);
        chk("R5 wrap", got_rd, 8'h00);
        cyc(0, 1, 8'h00, 0, 1); chk("R6 ack clears", {7'd0, got_irq}, 8'h00);

        // R9 match write, read returns count
        cyc(1, 1, 8'h03, 0, 0); chk("R9 read is count", got_rd, 8'h00);
        for (int i = 0; i < 3; i++) cyc(0, 1, 8'h00, 1, 0);
        chk("R5 count 3", got_rd, 8'h03);
        chk("R5 no event", {7'd0, got_irq}, 8'h00);
        cyc(0, 1, 8'h00, 1, 0);
        chk("R5 event after match+1", {7'd0, got_irq}, 8'h01);
        cyc(0, 1, 8'h00, 0, 0); chk("R6 held", {7'd0, got_irq}, 8'h01);
        cyc(0, 1, 8'h00, 0, 1); chk("R6 ack", {7'd0, got_irq}, 8'h00);

        // R7 watchdog mode
        cyc(1, 0, 8'hC0, 0, 0);
        for (int i = 0; i < 4; i++) cyc(0, 1, 8'h00, 1, 0);
        chk("R7 rst pulse", {7'd0, got_rst}, 8'h01);
        chk("R7 no irq", {7'd0, got_irq}, 8'h00);
        cyc(0, 1, 8'h00, 0, 0); chk("R7 one cycle", {7'd0, got_rst}, 8'h00);

        // R4 divide by 4, match 0
        cyc(1, 0, 8'h82, 0, 0);
        cyc(1, 1, 8'h00, 0, 0);
        for (int i = 0; i < 3; i++) cyc(0, 1, 8'h00, 1, 0);
        chk("R4 no event before 4th", {7'd0, got_irq}, 8'h00);
        cyc(0, 1, 8'h00, 1, 0);
        chk("R4 event at 4th", {7'd0, got_irq}, 8'h01);
        cyc(0, 1, 8'h00, 0, 1);

        // R8 clear wins over match
        cyc(1, 0, 8'h80, 0, 0);
        cyc(1, 1, 8'h03, 0, 0);
        for (int i = 0; i < 3; i++) cyc(0, 1, 8'h00, 1, 0);
        chk("R8 count 3", got_rd, 8'h03);
        cyc(1, 0, 8'hA0, 1, 0);
        chk("R8 bit5 reads 1", got_rd, 8'hA0);
        chk("R8 no event", {7'd0, got_irq}, 8'h00);
        cyc(0, 0, 8'h00, 0, 0); chk("R8 bit5 self clears", got_rd, 8'h80);
        cyc(0, 1, 8'h00, 0, 0); chk("R8 count cleared", got_rd, 8'h00);

        // R3 enable gates counting
        cyc(0, 1, 8'h00, 1, 0); cyc(0, 1, 8'h00, 1, 0);
        chk("R3 counted", got_rd, 8'h02);
        cyc(1, 0, 8'h00, 0, 0);
        for (int i = 0; i < 5; i++) cyc(0, 1, 8'h00, 1, 0);
        chk("R3 held while disabled", got_rd, 8'h02);

        // random phase
        for (int i = 0; i < 6000; i++) begin
            logic we, a, tk, ak;
            logic [7:0] wd;
            we = ($urandom % 8) == 0;
            a  = 1'($urandom % 2);
            wd = 8'($urandom);
            if (we && a) wd = wd & 8'h0F;
            if (we && !a) wd[7] = ($urandom % 4) != 0;
            tk = 1'($urandom % 2);
            ak = ($urandom % 8) == 0;
            cyc(we, a, wd, tk, ak);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule